// File: doc/BRIEF.md
# Conditional Termination Flag Unit

This block evaluates the scalar compare that decides whether a loop ends early. It takes two scalar operands, a width select and an equal/not-equal select. From these it produces an updated four-bit condition-flag vector. Unlike an ordinary compare, it rewrites only two of the four flags. The negative flag carries the compare outcome. The overflow flag is set only when the compare outcome is false and the incoming carry is clear. The zero and carry flags leave the block exactly as they arrived.

A request is offered by raising `req_valid` with the operands and the current flag vector. On the next rising clock edge the result is captured in an output register. A two-state machine (`ST_IDLE`, `ST_REPORT`) raises `rsp_valid` for one cycle per accepted request. Every cycle that carries a request moves the machine to `ST_REPORT`, and every cycle without one moves it to `ST_IDLE`. Back-to-back requests therefore keep it in `ST_REPORT`. Between requests the flag output holds its last value.

Top module: `cterm_flag_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no request, `rsp_valid` is 0 and `flags_out` is 4'b0000.
- R2: A request sampled at a rising edge produces `rsp_valid`=1 and its result on `flags_out` after that edge. `rsp_valid` is 1 in exactly the cycles that follow a sampled request, so back-to-back requests give back-to-back results.
- R3: With `ne_sel`=0, the N flag (`flags_out[3]`) is 1 when the compared operand bits are equal, and 0 otherwise.
- R4: With `ne_sel`=1, the N flag is 1 when the compared operand bits differ, and 0 otherwise.
- R5: With `wide_sel`=0, only bits [31:0] of each operand are compared. Differences in bits [63:32] have no effect on N.
- R6: With `wide_sel`=1, all 64 bits of each operand are compared. A difference in any single bit, including bit 32 or bit 63, counts.
- R7: The V flag (`flags_out[0]`) equals (NOT N) AND (NOT C_in). C_in is the incoming carry `flags_in[1]` of the same request.
- R8: The Z flag (`flags_out[2]`) and the C flag (`flags_out[1]`) equal `flags_in[2]` and `flags_in[1]` of the same request. `flags_in[3]` and `flags_in[0]` do not affect the result.
- R9: In a cycle following an edge where `req_valid` was 0, `rsp_valid` is 0 and `flags_out` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| opnd_a | input | 64 | First scalar operand |
| opnd_b | input | 64 | Second scalar operand |
| wide_sel | input | 1 | 1: compare 64 bits, 0: compare low 32 bits |
| ne_sel | input | 1 | 0: test equality, 1: test inequality |
| flags_in | input | 4 | Current flags, bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| rsp_valid | output | 1 | Result on flags_out is new this cycle |
| flags_out | output | 4 | Updated flags, same bit order as flags_in |

## Verification
Several operand pairs differ only in the upper half. A unit that ignored `wide_sel` would report equality wrongly in 64-bit mode, or inequality wrongly in 32-bit mode. Other pairs differ only at bit 31 or only at bit 32, which catches a boundary off by one between the halves. Every combination of incoming flags is swept with both selects. A unit that forgot to invert N, that took V from the new carry or from the old V, or that let Z or C change would miscompare. A hold phase changes all inputs with the request low, and a reset check runs mid-stream. Together they expose an output register that loads without a request, or a strobe that sticks high.

// File: rtl/cterm_pkg.sv
package cterm_pkg;

    // Condition flag vector, MSB first: N, Z, C, V
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } cterm_state_e;

endpackage

// File: rtl/cterm_operand_cmp.sv
module cterm_operand_cmp #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              wide_i,
    input  logic              ne_i,
    output logic              hit_o
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic lo_same;
    logic hi_same;
    logic same;

    assign lo_same = (a_i[NARROW_W-1:0] == b_i[NARROW_W-1:0]);

    generate
        if (HI_W > 0) begin : g_upper
            assign hi_same = (a_i[DATA_W-1:NARROW_W] == b_i[DATA_W-1:NARROW_W]);
        end else begin : g_no_upper
            assign hi_same = 1'b1;
        end
    endgenerate

    // upper half only matters in wide mode
    assign same  = lo_same & (hi_same | ~wide_i);
    assign hit_o = ne_i ? ~same : same;

endmodule

// File: rtl/cterm_flag_calc.sv
module cterm_flag_calc
    import cterm_pkg::*;
(
    input  logic        hit_i,
    input  cond_flags_t flags_i,
    output cond_flags_t flags_o
);
    always_comb begin
        flags_o   = flags_i;            // Z and C pass through
        flags_o.n = hit_i;
        flags_o.v = ~hit_i & ~flags_i.c; // uses carry before the update
    end
endmodule

// File: rtl/cterm_flag_unit.sv
module cterm_flag_unit
    import cterm_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              wide_sel,
    input  logic              ne_sel,
    input  logic [3:0]        flags_in,
    output logic              rsp_valid,
    output logic [3:0]        flags_out
);
    cterm_state_e state_q, state_d;
    cond_flags_t  flags_next;
    cond_flags_t  flags_q;
    logic         hit;

    cterm_operand_cmp #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_cmp (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .wide_i (wide_sel),
        .ne_i   (ne_sel),
        .hit_o  (hit)
    );

    cterm_flag_calc u_calc (
        .hit_i   (hit),
        .flags_i (cond_flags_t'(flags_in)),
        .flags_o (flags_next)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                flags_q <= flags_next;
            end
        end
    end

    // outputs
    always_comb begin
        rsp_valid = (state_q == ST_REPORT);
        flags_out = flags_q;
    end

    AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid)); // R2

    AST_V_FROM_OLD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> (flags_out[0] == (~flags_out[3] & ~$past(flags_in[1])))); // R7

    AST_ZC_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> (flags_out[2:1] == $past(flags_in[2:1]))); // R8

    AST_HOLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable(flags_out)); // R9

    AST_NARROW_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && !$past(wide_sel) &&
         ($past(opnd_a[NARROW_W-1:0]) == $past(opnd_b[NARROW_W-1:0])))
        |-> (flags_out[3] == !$past(ne_sel))); // R5

endmodule

// File: tb/cterm_flag_unit_test.sv
module cterm_flag_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        wide_sel = 1'b0;
    logic        ne_sel = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        rsp_valid;
    logic [3:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cterm_flag_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .wide_sel  (wide_sel),
        .ne_sel    (ne_sel),
        .flags_in  (flags_in),
        .rsp_valid (rsp_valid),
        .flags_out (flags_out)
    );

    // operand pairs {a, b}
    localparam logic [127:0] PAIRS [8] = '{
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
        {64'hFFFF_0000_0000_0005, 64'h0000_0000_0000_0005},  // upper differs only
        {64'h8000_0000_ABCD_0001, 64'h0000_0000_ABCD_0001},  // bit 63 only
        {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},  // bit 0 only
        {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000},  // bit 31 only
        {64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000},  // bit 32 only
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}
    };

    function automatic logic [3:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic w, input logic ne, input logic [3:0] f);
        logic eq, n, v;
        eq = w ? (a == b) : (a[31:0] == b[31:0]);
        n  = ne ? !eq : eq;
        v  = !n && !f[1];
        return {n, f[2], f[1], v};
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,flags} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [3:0] exp_f;
        logic [3:0] held;
        string      tag;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 during reset", {rsp_valid, flags_out}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {rsp_valid, flags_out}, 5'b0);

        // exhaustive sweep: pairs x width x ne x incoming flags, back-to-back
        for (int p = 0; p < 8; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int f = 0; f < 16; f++) begin
                        opnd_a    = PAIRS[p][127:64];
                        opnd_b    = PAIRS[p][63:0];
                        wide_sel  = w[0];
                        ne_sel    = e[0];
                        flags_in  = f[3:0];
                        req_valid = 1'b1;
                        exp_f = model(opnd_a, opnd_b, wide_sel, ne_sel, flags_in);
                        @(negedge clk);
                        tag = {(e != 0) ? "R4" : "R3", (w != 0) ? " R6" : " R5",
                               " R7 R8 R2"};
                        check(tag, {rsp_valid, flags_out}, {1'b1, exp_f});
                    end
                end
            end
        end

        // R9: hold with no request while inputs change
        held = flags_out;
        req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            opnd_a   = {32'hDEAD_BEEF, 32'h0000_1000 + k};
            opnd_b   = 64'h0;
            wide_sel = k[0];
            ne_sel   = k[1];
            flags_in = 4'(k * 5);
            @(negedge clk);
            check("R9 hold", {rsp_valid, flags_out}, {1'b0, held});
        end

        // R2: single isolated request gives a one-cycle strobe
        opnd_a = 64'h0000_0007_0000_0009; opnd_b = 64'h0000_0003_0000_0009;
        wide_sel = 1'b0; ne_sel = 1'b0; flags_in = 4'b0000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 R5 single", {rsp_valid, flags_out}, 5'b1_1000);
        @(negedge clk);
        check("R2 strobe drops", {rsp_valid, flags_out}, 5'b0_1000);

        // R6 / R7: wide mode sees upper difference, carry clear sets V
        opnd_a = 64'h0000_0007_0000_0009; opnd_b = 64'h0000_0003_0000_0009;
        wide_sel = 1'b1; ne_sel = 1'b0; flags_in = 4'b1001; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 R7 wide", {rsp_valid, flags_out}, 5'b1_0001);

        // R1: reset in mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", {rsp_valid, flags_out}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after mid reset", {rsp_valid, flags_out}, 5'b0);

        finished = 1'b1;
        summary();
    end
endmodule